// File: doc/BRIEF.md
# Command Block Register-Write Decoder

The decoder sits between a fetch engine that streams 32-bit words out of a command buffer in memory and a drawing engine that accepts register writes. The words are taken five at a time. The first word of each group is a header that packs four 8-bit register indices. The next four words are the values for those indices. Each index is expanded into a full byte address in one of two 512-byte register windows, and the value is then handed to the write sink. Two indices are handled inside the block and never reach the sink. The padding index fills an unused slot. The soft-trap index marks the end of a list and raises an interrupt.

Software sets the list length through a small control port. It writes the start address first. Writing the end address then starts the decoder, which consumes (end - start) / 4 words. The block also holds an interrupt enable register and a status register, and a write-one-to-clear register clears status bits. A write to the mode register stops a list that is in progress. A list whose length is not a whole number of blocks has its trailing words discarded, and a sticky error output is raised.

The control offsets are: 0x00 start address, 0x04 end address, 0x08 interrupt enable, 0x0C interrupt clear, 0x10 interrupt status (read) and 0x14 mode.

Sequencer states:
- `ST_IDLE`: waits for an end-address write.
- `ST_HEAD`: waits for a header word.
- `ST_VALUE`: waits for the value word of the current slot.
- `ST_ISSUE`: holds a write until the sink takes it.
- `ST_DISCARD`: swallows a trailing partial block.

Transitions:
- IDLE→HEAD when the end address is written with a non-zero length.
- HEAD→VALUE when a header is accepted.
- HEAD→DISCARD when fewer than five words remain.
- VALUE→ISSUE when a normal value is accepted.
- VALUE→VALUE when a pad or trap slot is accepted and it is not the last slot.
- ISSUE→VALUE when the sink accepts and it is not the last slot.
- VALUE or ISSUE→HEAD or IDLE when the last slot is done, depending on the words left.
- DISCARD→IDLE when the last word is swallowed.
- Any state→IDLE on a mode-register write.

Top module: `cmd_block_decoder`

## Requirements
- R1: Five words form one block. Header bits 7:0, 15:8, 23:16 and 31:24 select the registers for value words 1, 2, 3 and 4. The writes leave the sink port in that slot order.
- R2: An index with bit 7 = 0 is written to byte address 0x1C00 + index[6:0]*4.
- R3: An index with bit 7 = 1 is written to byte address 0x2C00 + index[6:0]*4.
- R4: Index 0x15 (address 0x1C54) is padding. Its value word is consumed and no write is produced.
- R5: Index 0x92 (address 0x2C48) is the soft trap. Its value word is consumed and not forwarded, and status bit 0 is set on the clock edge that accepts the word.
- R6: A write to the clear register clears each status bit whose data bit is 1. Writing 0xF clears bits 3:0. A bit written as 0 is left as it is.
- R7: `irq` is high exactly when some status bit and its enable bit are both 1. An enable value of 0 masks every source.
- R8: Writing the end address while idle starts a list of (end - start)/4 words. A length of zero leaves the decoder idle with `wd_ready` low.
- R9: While a write is pending (`wr_valid` high), `wd_ready` is low, and `wr_addr`/`wr_data` stay stable until `wr_ready` is seen.
- R10: A mode-register write aborts a list. From the next cycle the decoder is idle, with `wd_ready` and `wr_valid` low, and the next end-address write starts a fresh list.
- R11: If fewer than five words remain when a header is due, those words are accepted and discarded. `cmd_err` is set, and it stays set until the next list starts.
- R12: A read at offset 0x10 returns the status bits and a read at offset 0x08 returns the enable bits. Other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 8 | Control register byte offset |
| cfg_wdata | input | 32 | Control write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| wd_valid | input | 1 | Command word valid |
| wd_data | input | 32 | Command word |
| wd_ready | output | 1 | Decoder accepts the word this cycle |
| wr_valid | output | 1 | Register write pending |
| wr_addr | output | 16 | Register byte address |
| wr_data | output | 32 | Register value |
| wr_ready | input | 1 | Sink takes the write this cycle |
| irq | output | 1 | Interrupt request |
| cmd_err | output | 1 | Sticky partial-block error |

## Verification
A value word accepted on edge E shows up on `wr_valid` right after E. It leaves on the first later edge where `wr_ready` is high. A trap word sets status, and therefore `irq`, on edge E itself. Control writes take effect on the edge that samples them, while `cfg_rdata` follows `cfg_addr` with no delay. The bench drives every input 1 ns after a falling edge and samples 1 ns after a falling edge, so every result is read a whole half-cycle after the edge that produced it. The scoreboard monitor compares a write against the queue on the sample where `wr_valid` and `wr_ready` are both high, which is the cycle just before the edge that completes the handshake.

// File: rtl/cmddec_pkg.sv
package cmddec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_VALUE,
        ST_ISSUE,
        ST_DISCARD
    } seq_state_e;

    localparam logic [7:0] OFS_START  = 8'h00;
    localparam logic [7:0] OFS_END    = 8'h04;
    localparam logic [7:0] OFS_ENABLE = 8'h08;
    localparam logic [7:0] OFS_CLEAR  = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_MODE   = 8'h14;

    localparam int unsigned SLOTS_PER_BLOCK = 4;
    localparam int unsigned WORDS_PER_BLOCK = SLOTS_PER_BLOCK + 1;

endpackage

// File: rtl/cmddec_index_map.sv
module cmddec_index_map #(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned RA_W      = 16,
    parameter logic [15:0] WIN0_BASE = 16'h1C00,
    parameter logic [15:0] WIN1_BASE = 16'h2C00,
    parameter logic [15:0] PAD_ADDR  = 16'h1C54,
    parameter logic [15:0] TRAP_ADDR = 16'h2C48
) (
    input  logic [IDX_W-1:0] idx,
    output logic [RA_W-1:0]  addr,
    output logic             is_pad,
    output logic             is_trap
);
    localparam int unsigned OFS_BITS = IDX_W - 1;

    logic [RA_W-1:0] base;
    logic [RA_W-1:0] offset;

    // The top index bit picks the window; the rest is a word offset.
    always_comb begin
        base   = idx[IDX_W-1] ? RA_W'(WIN1_BASE) : RA_W'(WIN0_BASE);
        offset = RA_W'({idx[OFS_BITS-1:0], 2'b00});
        addr   = base + offset;
    end

    assign is_pad  = (addr == RA_W'(PAD_ADDR));
    assign is_trap = (addr == RA_W'(TRAP_ADDR));

endmodule

// File: rtl/cmddec_irq.sv
module cmddec_irq #(
    parameter int unsigned NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_src,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_mask,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_val,
    output logic [NSRC-1:0] status,
    output logic [NSRC-1:0] enable,
    output logic            irq
);
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] enable_q;

    // One status flop per source: a new event beats a clear in the same cycle.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[i] <= 1'b0;
            end else if (set_src[i]) begin
                status_q[i] <= 1'b1;
            end else if (clr_we && clr_mask[i]) begin
                status_q[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_we) begin
            enable_q <= en_val;
        end
    end

    assign status = status_q;
    assign enable = enable_q;
    assign irq    = |(status_q & enable_q);

endmodule

// File: rtl/cmddec_seq.sv
module cmddec_seq
    import cmddec_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned RA_W   = 16,
    parameter int unsigned CNT_W  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_words,
    input  logic              abort,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              wr_valid,
    output logic [RA_W-1:0]   wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              trap_hit,
    output logic              cmd_err
);
    localparam int unsigned IDX_W  = WORD_W / SLOTS_PER_BLOCK;
    localparam int unsigned SLOT_W = $clog2(SLOTS_PER_BLOCK);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_BLOCK - 1);
    localparam logic [CNT_W-1:0]  BLOCK_WORDS = CNT_W'(WORDS_PER_BLOCK);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [WORD_W-1:0] hdr_q;
    logic [CNT_W-1:0]  left_q;
    logic [RA_W-1:0]   addr_q;
    logic [WORD_W-1:0] data_q;
    logic              err_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [RA_W-1:0]   cur_addr;
    logic              cur_pad;
    logic              cur_trap;
    logic              take;
    logic              short_list;
    logic              last_slot;

    always_comb begin
        cur_idx = '0;
        for (int s = 0; s < SLOTS_PER_BLOCK; s++) begin
            if (slot_q == SLOT_W'(s)) begin
                cur_idx = hdr_q[s*IDX_W +: IDX_W];
            end
        end
    end

    cmddec_index_map #(
        .IDX_W (IDX_W),
        .RA_W  (RA_W)
    ) u_map (
        .idx     (cur_idx),
        .addr    (cur_addr),
        .is_pad  (cur_pad),
        .is_trap (cur_trap)
    );

    assign short_list = (left_q < BLOCK_WORDS);
    assign last_slot  = (slot_q == LAST_SLOT);
    assign take       = wd_valid && wd_ready;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && (start_words != '0)) begin
                    state_d = ST_HEAD;
                end
            end
            ST_HEAD: begin
                if (short_list) begin
                    state_d = ST_DISCARD;
                end else if (wd_valid) begin
                    state_d = ST_VALUE;
                end
            end
            ST_VALUE: begin
                if (wd_valid) begin
                    if (!(cur_pad || cur_trap)) begin
                        state_d = ST_ISSUE;
                    end else if (!last_slot) begin
                        state_d = ST_VALUE;
                    end else if (left_q == CNT_W'(1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_HEAD;
                    end
                end
            end
            ST_ISSUE: begin
                if (wr_ready) begin
                    if (!last_slot) begin
                        state_d = ST_VALUE;
                    end else if (left_q == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_HEAD;
                    end
                end
            end
            ST_DISCARD: begin
                if (wd_valid && (left_q == CNT_W'(1))) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            hdr_q  <= '0;
            left_q <= '0;
            addr_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else if (!abort) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        left_q <= start_words;
                        slot_q <= '0;
                        err_q  <= 1'b0;
                    end
                end
                ST_HEAD: begin
                    if (short_list) begin
                        err_q <= 1'b1;
                    end else if (take) begin
                        hdr_q  <= wd_data;
                        left_q <= left_q - CNT_W'(1);
                        slot_q <= '0;
                    end
                end
                ST_VALUE: begin
                    if (take) begin
                        left_q <= left_q - CNT_W'(1);
                        if (cur_pad || cur_trap) begin
                            slot_q <= slot_q + SLOT_W'(1);
                        end else begin
                            addr_q <= cur_addr;
                            data_q <= wd_data;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (wr_ready) begin
                        slot_q <= slot_q + SLOT_W'(1);
                    end
                end
                ST_DISCARD: begin
                    if (take) begin
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        wd_ready = 1'b0;
        wr_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_HEAD:    wd_ready = !short_list;
            ST_VALUE:   wd_ready = 1'b1;
            ST_ISSUE:   wr_valid = 1'b1;
            ST_DISCARD: wd_ready = 1'b1;
            default:    ;
        endcase
        if (abort) begin
            wd_ready = 1'b0;
        end
    end

    assign trap_hit = (state_q == ST_VALUE) && take && cur_trap;
    assign wr_addr  = addr_q;
    assign wr_data  = data_q;
    assign cmd_err  = err_q;

endmodule

// File: rtl/cmd_block_decoder.sv
module cmd_block_decoder
    import cmddec_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned RA_W   = 16,
    parameter int unsigned NSRC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    output logic              wd_ready,
    output logic              wr_valid,
    output logic [RA_W-1:0]   wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              irq,
    output logic              cmd_err
);
    localparam int unsigned CNT_W = WORD_W - 2;

    logic [WORD_W-1:0] start_q;
    logic [WORD_W-1:0] span;
    logic              unused_span_lsb;
    logic              end_we;
    logic              mode_we;
    logic              trap_w;
    logic [NSRC-1:0]   status_w;
    logic [NSRC-1:0]   enable_w;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (cfg_we && (cfg_addr == OFS_START)) begin
            start_q <= cfg_wdata;
        end
    end

    assign span            = cfg_wdata - start_q;
    assign unused_span_lsb = ^span[1:0];
    assign end_we          = cfg_we && (cfg_addr == OFS_END);
    assign mode_we         = cfg_we && (cfg_addr == OFS_MODE);

    cmddec_seq #(
        .WORD_W (WORD_W),
        .RA_W   (RA_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (end_we),
        .start_words (span[WORD_W-1:2]),
        .abort       (mode_we),
        .wd_valid    (wd_valid),
        .wd_data     (wd_data),
        .wd_ready    (wd_ready),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .trap_hit    (trap_w),
        .cmd_err     (cmd_err)
    );

    cmddec_irq #(
        .NSRC (NSRC)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_src  ({{(NSRC-1){1'b0}}, trap_w}),
        .clr_we   (cfg_we && (cfg_addr == OFS_CLEAR)),
        .clr_mask (cfg_wdata[NSRC-1:0]),
        .en_we    (cfg_we && (cfg_addr == OFS_ENABLE)),
        .en_val   (cfg_wdata[NSRC-1:0]),
        .status   (status_w),
        .enable   (enable_w),
        .irq      (irq)
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == OFS_STATUS) begin
            cfg_rdata = WORD_W'(status_w);
        end else if (cfg_addr == OFS_ENABLE) begin
            cfg_rdata = WORD_W'(enable_w);
        end
    end

endmodule

// File: rtl/cmddec_checker.sv
module cmddec_checker
    import cmddec_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [7:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic        wd_ready,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [15:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        irq,
    input logic        trap,
    input logic [3:0]  status
);
    // R9: a stalled write holds its address and data
    a_r9_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R9: no word is taken while a write is pending
    a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !wd_ready);

    // R2, R3: every forwarded address lies word-aligned in one of the windows
    a_r2_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00) &&
                     ((wr_addr >= 16'h1C00 && wr_addr <= 16'h1DFF) ||
                      (wr_addr >= 16'h2C00 && wr_addr <= 16'h2DFF)));

    // R4, R5: pad and trap never reach the sink
    a_r4_r5_internal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr != 16'h1C54) && (wr_addr != 16'h2C48));

    // R5: a trap sets status bit 0
    a_r5_trap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> status[0]);

    // R6: a clear with bit 0 set clears status bit 0 when no trap competes
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == OFS_CLEAR) && cfg_wdata[0] && !trap |=> !status[0]);

    // R7: an all-zero enable masks the interrupt
    a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == OFS_ENABLE) && (cfg_wdata[3:0] == 4'h0) |=> !irq);

    // R10: a mode write leaves the decoder idle on the next cycle
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_addr == OFS_MODE) |=> !wr_valid && !wd_ready);

endmodule

bind cmd_block_decoder cmddec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .wd_ready  (wd_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq       (irq),
    .trap      (trap_w),
    .status    (status_w)
);

// File: tb/sim_cmd_block_decoder.sv
`timescale 1ns/1ps
module sim_cmd_block_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic        wd_ready;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        irq;
    logic        cmd_err;

    int errors = 0;
    int checks = 0;
    bit stall_en = 1'b0;
    int cyc = 0;
    int stall_viol = 0;
    int hold_viol = 0;
    int unexpected = 0;

    logic [15:0] q_addr[$];
    logic [31:0] q_data[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    cmd_block_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wd_valid(wd_valid),
        .wd_data(wd_data), .wd_ready(wd_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .irq(irq), .cmd_err(cmd_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Sink: always ready, or ready one cycle in four when stalling.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        wr_ready <= stall_en ? (cyc[1:0] == 2'b00) : 1'b1;
    end

    // Monitor / scoreboard.
    logic        prev_stall = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [31:0] prev_data = '0;
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (wr_valid && wd_ready) stall_viol++;
            if (prev_stall && !(wr_valid && wr_addr == prev_addr && wr_data == prev_data))
                hold_viol++;
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
            if (wr_valid && wr_ready) begin
                if (q_addr.size() == 0) begin
                    unexpected++;
                    check(1'b0, "R4", "unexpected write", {16'h0, wr_addr}, 32'h0);
                end else begin
                    logic [15:0] ea;
                    logic [31:0] ed;
                    string tg;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    tg = q_tag.pop_front();
                    check(wr_addr == ea, tg, "write address", {16'h0, wr_addr}, {16'h0, ea});
                    check(wr_data == ed, tg, "write data", wr_data, ed);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); #1;
        cfg_we = 1'b0; cfg_addr = 8'h00;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a; #0.5; d = cfg_rdata; cfg_addr = 8'h00;
    endtask

    task automatic push_word(input logic [31:0] w);
        wd_valid = 1'b1; wd_data = w;
        #0.5;
        while (!wd_ready) begin
            @(negedge clk); #1;
        end
        @(negedge clk); #1;
        wd_valid = 1'b0;
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic start_list(input logic [31:0] s, input int words);
        cfg_write(8'h00, s);
        cfg_write(8'h04, s + 32'(words * 4));
    endtask

    task automatic drain(input string tag);
        repeat (30) @(negedge clk);
        #1;
        check(q_addr.size() == 0, tag, "pending expected writes", q_addr.size(), 0);
    endtask

    initial begin
        logic [31:0] rd;
        @(negedge clk); #1;
        repeat (3) @(negedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk); #1;

        // Reset state
        check(irq == 1'b0, "R7", "irq after reset", irq, 0);
        check(wr_valid == 1'b0, "R9", "wr_valid after reset", wr_valid, 0);
        check(wd_ready == 1'b0, "R8", "wd_ready when idle", wd_ready, 0);
        check(cmd_err == 1'b0, "R11", "err after reset", cmd_err, 0);
        cfg_read(8'h10, rd);
        check(rd == 0, "R12", "status after reset", rd, 0);

        cfg_write(8'h08, 32'h1);
        cfg_read(8'h08, rd);
        check(rd == 32'h1, "R12", "enable read-back", rd, 32'h1);
        cfg_read(8'h20, rd);
        check(rd == 0, "R12", "unmapped offset", rd, 0);

        // Two blocks; the first one with a stalling sink (R1, R2, R3, R9)
        stall_en = 1'b1;
        start_list(32'h1000, 10);
        expect_wr(16'h1C00, 32'hA000_0000, "R2");
        expect_wr(16'h1DFC, 32'hA000_0001, "R2");
        expect_wr(16'h1C0C, 32'hA000_0002, "R1");
        expect_wr(16'h2C14, 32'hA000_0003, "R3");
        push_word(32'h8503_7F00);
        push_word(32'hA000_0000);
        push_word(32'hA000_0001);
        push_word(32'hA000_0002);
        push_word(32'hA000_0003);
        stall_en = 1'b0;
        // pad, 0xFF, pad, trap (R3, R4, R5)
        expect_wr(16'h2DFC, 32'hB000_0001, "R3");
        push_word(32'h9215_FF15);
        push_word(32'hB000_0000);
        push_word(32'hB000_0001);
        push_word(32'hB000_0002);
        push_word(32'hB000_0003);
        cfg_read(8'h10, rd);
        check(rd == 32'h1, "R5", "status after trap", rd, 32'h1);
        check(irq == 1'b1, "R7", "irq with enable set", irq, 1);
        drain("R4");
        check(wd_ready == 1'b0, "R8", "idle after list", wd_ready, 0);
        check(cmd_err == 1'b0, "R11", "no error on whole blocks", cmd_err, 0);

        // Masking and clearing (R6, R7)
        cfg_write(8'h08, 32'h0);
        check(irq == 1'b0, "R7", "irq masked", irq, 0);
        cfg_write(8'h0C, 32'hE);
        cfg_read(8'h10, rd);
        check(rd == 32'h1, "R6", "clear with bit0=0 keeps status", rd, 32'h1);
        cfg_write(8'h0C, 32'hF);
        cfg_read(8'h10, rd);
        check(rd == 32'h0, "R6", "clear 0xF", rd, 32'h0);
        cfg_write(8'h08, 32'h1);
        check(irq == 1'b0, "R7", "irq with status clear", irq, 0);

        // Partial list: 7 words (R11)
        start_list(32'h2000, 7);
        expect_wr(16'h1C04, 32'hC000_0000, "R11");
        expect_wr(16'h1C08, 32'hC000_0001, "R11");
        expect_wr(16'h1C0C, 32'hC000_0002, "R11");
        expect_wr(16'h1C10, 32'hC000_0003, "R11");
        push_word(32'h0403_0201);
        push_word(32'hC000_0000);
        push_word(32'hC000_0001);
        push_word(32'hC000_0002);
        push_word(32'hC000_0003);
        push_word(32'hDEAD_0000);
        push_word(32'hDEAD_0001);
        drain("R11");
        check(cmd_err == 1'b1, "R11", "sticky error", cmd_err, 1);
        check(wd_ready == 1'b0, "R11", "idle after discard", wd_ready, 0);

        // Abort mid-list (R10)
        start_list(32'h3000, 5);
        check(cmd_err == 1'b0, "R11", "error cleared on new list", cmd_err, 0);
        expect_wr(16'h1C04, 32'hE000_0000, "R10");
        push_word(32'h0403_0201);
        push_word(32'hE000_0000);
        drain("R10");
        check(wd_ready == 1'b1, "R10", "waiting on slot 1", wd_ready, 1);
        cfg_write(8'h14, 32'h0);
        check(wd_ready == 1'b0, "R10", "ready after abort", wd_ready, 0);
        check(wr_valid == 1'b0, "R10", "no write after abort", wr_valid, 0);

        // Fresh list after abort
        start_list(32'h3000, 5);
        expect_wr(16'h2C00, 32'hF000_0000, "R10");
        expect_wr(16'h2C04, 32'hF000_0001, "R10");
        expect_wr(16'h2C08, 32'hF000_0002, "R10");
        expect_wr(16'h2C0C, 32'hF000_0003, "R10");
        push_word(32'h8382_8180);
        push_word(32'hF000_0000);
        push_word(32'hF000_0001);
        push_word(32'hF000_0002);
        push_word(32'hF000_0003);
        drain("R10");

        // Zero-length list (R8)
        start_list(32'h4000, 0);
        @(negedge clk); #1;
        check(wd_ready == 1'b0, "R8", "zero length stays idle", wd_ready, 0);

        check(stall_viol == 0, "R9", "ready during pending write", stall_viol, 0);
        check(hold_viol == 0, "R9", "stalled write changed", hold_viol, 0);
        check(unexpected == 0, "R4", "unexpected writes", unexpected, 0);
        summary();
    end

endmodule